// File: doc/BRIEF.md
# Oversampled Serial Receiver with Tagged Character Queue

This block recovers asynchronous serial characters from a single receive line. A baud enable tick arrives sixteen times per bit period. The block resynchronises its bit timing to the falling edge that begins each character. It takes a majority vote around the middle of every bit, checks an optional parity bit and tests the stop bit.

Each finished character goes into a two-entry queue. Its parity and framing verdicts travel with it, so the status flags at the read side always describe the character at the head of the queue and not the latest event on the line. A host pops the head with a one-cycle read strobe. The receive-ready flag stays high while the queue holds anything, so a host can flush the queue by reading until the flag drops.

Clearing the enable input stops reception at once. It abandons the character in progress and empties the queue. Baud rate generation, transmission, interrupts and bus decoding are handled elsewhere.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset, rxReady, parityErr, frameErr and overrunFlag are all 0 and dataOut is 0.
- R2: A character is a low start bit, then 5, 6, 7 or 8 data bits (lenSel = 0, 1, 2, 3) sent least significant bit first, then an optional parity bit, then a high stop bit. The received value appears on dataOut right-aligned, with its upper bits zero.
- R3: Each bit lasts 16 baud ticks, with sample 0 being the tick that sees the falling start edge. The bit value is the majority of samples 7, 8 and 9, so a single corrupted sample in that window, or any corruption outside it, does not change the result. Two corrupted samples in the window do change it.
- R4: A falling edge whose start bit reads high by majority at mid-bit is treated as noise. The receiver returns to idle and queues nothing.
- R5: With parEnable = 1, a parity bit follows the data. parOdd = 0 selects even parity (data bits plus parity bit have an even count of ones) and parOdd = 1 selects odd parity. A mismatch sets parityErr for that character only.
- R6: lenSel, parEnable and parOdd are captured at the start edge, and changing them mid-character has no effect on that character. With parEnable = 0 no parity bit is expected and parityErr is 0.
- R7: A stop bit sampled low sets frameErr for that character. The character is still queued.
- R8: The queue holds 2 characters. rxReady is 1 while it is non-empty, and dataOut, parityErr and frameErr show the head. A readStrobe pops the head. A readStrobe on an empty queue has no effect.
- R9: A character that completes while the queue is full and no pop happens in the same cycle is dropped, and overrunFlag is set. The queued characters are unchanged. overrunFlag clears on the next pop or when the receiver is disabled.
- R10: If a character completes in the same cycle as a pop from a full queue, both take effect: the queue stays full, the new character becomes the tail and overrunFlag stays 0.
- R11: enable = 0 empties the queue and clears overrunFlag at the next clock, abandons any character in progress, and ignores the line until enable returns to 1.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Receiver enable; low aborts and flushes |
| baudTick | input | 1 | One-cycle pulse, 16 per bit period |
| rxLine | input | 1 | Serial input, idle high |
| parEnable | input | 1 | Expect and check a parity bit |
| parOdd | input | 1 | 1 = odd parity, 0 = even parity |
| lenSel | input | 2 | Data length code: 5 + lenSel bits |
| readStrobe | input | 1 | Pop the head character |
| dataOut | output | 8 | Head character, right-aligned |
| rxReady | output | 1 | Queue holds at least one character |
| parityErr | output | 1 | Parity verdict of the head character |
| frameErr | output | 1 | Stop-bit verdict of the head character |
| overrunFlag | output | 1 | A character was dropped on a full queue |

## Verification
Two operations can fall in the same clock cycle: the stop-bit decision that pushes a new character, and a host pop. The bench fills the queue with two characters, then sends a third and raises readStrobe in exactly the tick cycle of the ninth stop-bit sample, which is the cycle in which the push happens. It then expects overrunFlag to be 0, the second character at the head, and the third character after one more pop. The same scenario without the pop has to give the opposite verdict, with the third character lost and overrunFlag raised.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Strobes from the frame controller to the datapath
  typedef struct packed {
    logic frameStart; // start edge accepted: clear the assembly registers
    logic dataBit;    // store bitVal at the data index
    logic parBit;     // compare bitVal against the running parity
    logic push;       // stop bit decided: bitVal is the stop level
    logic flush;      // receiver disabled
    logic bitVal;     // majority-voted bit value
    logic parOdd;     // parity sense captured at frame start
  } rxStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_e;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int DATA_W   = 8,
  parameter int LEN_W    = 2,
  parameter int MIN_BITS = 5,
  localparam int CNT_W   = $clog2(OSR),
  localparam int IDX_W   = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             baudTick,
  input  logic             rxIn,
  input  logic             parEnCfg,
  input  logic             parOddCfg,
  input  logic [LEN_W-1:0] lenCfg,
  output rxStrobe_t        strb,
  output logic [IDX_W-1:0] bitIdx
);

  localparam int MID   = OSR / 2;
  localparam int S_LO  = MID - 1;
  localparam int S_HI  = MID + 1;

  rxState_e         state;
  logic [CNT_W-1:0] tickCnt;
  logic             lastRx;
  logic             sampA, sampB;
  logic [LEN_W-1:0] lenL;
  logic             parEnL, oddL;
  logic             vote, atVote, atEnd;
  logic [IDX_W-1:0] lastIdx;

  assign vote    = (sampA & sampB) | (sampA & rxIn) | (sampB & rxIn);
  assign atVote  = baudTick && (tickCnt == CNT_W'(S_HI));
  assign atEnd   = (tickCnt == CNT_W'(OSR - 1));
  assign lastIdx = IDX_W'(MIN_BITS - 1) + IDX_W'(lenL);

  always_comb begin
    strb            = '0;
    strb.bitVal     = vote;
    strb.parOdd     = oddL;
    strb.flush      = !enable;
    strb.frameStart = enable && (state == ST_IDLE) && baudTick && !rxIn && lastRx;
    strb.dataBit    = enable && (state == ST_DATA) && atVote;
    strb.parBit     = enable && (state == ST_PAR) && atVote;
    strb.push       = enable && (state == ST_STOP) && atVote;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      lastRx  <= 1'b1;
      sampA   <= 1'b1;
      sampB   <= 1'b1;
      bitIdx  <= '0;
      lenL    <= '0;
      parEnL  <= 1'b0;
      oddL    <= 1'b0;
    end else begin
      if (baudTick) lastRx <= rxIn;
      if (!enable) begin
        state <= ST_IDLE;
      end else if (baudTick) begin
        if (tickCnt == CNT_W'(S_LO)) sampA <= rxIn;
        if (tickCnt == CNT_W'(MID))  sampB <= rxIn;
        if (state != ST_IDLE) tickCnt <= atEnd ? '0 : tickCnt + CNT_W'(1);
        case (state)
          ST_IDLE: begin
            if (!rxIn && lastRx) begin
              state   <= ST_START;
              tickCnt <= CNT_W'(1);
              bitIdx  <= '0;
              lenL    <= lenCfg;
              parEnL  <= parEnCfg;
              oddL    <= parOddCfg;
            end
          end
          ST_START: begin
            if (atVote && vote) state <= ST_IDLE;
            else if (atEnd)     state <= ST_DATA;
          end
          ST_DATA: begin
            if (atEnd) begin
              if (bitIdx == lastIdx) state <= parEnL ? ST_PAR : ST_STOP;
              else                   bitIdx <= bitIdx + IDX_W'(1);
            end
          end
          ST_PAR: begin
            if (atEnd) state <= ST_STOP;
          end
          ST_STOP: begin
            if (atVote) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              readStrobe,
  output logic [DATA_W-1:0] dataOut,
  output logic              rxReady,
  output logic              parityErr,
  output logic              frameErr,
  output logic              overrunFlag,
  output logic [CNT_W-1:0]  fillCount
);

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              pErr;
    logic              fErr;
  } entry_t;

  entry_t [DEPTH-1:0] slots;
  logic [DATA_W-1:0]  asmData;
  logic               asmPerr;
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic               full, pop, accept;
  entry_t             newEntry, headEntry;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full     = (fillCount == CNT_W'(DEPTH));
  assign pop      = readStrobe && rxReady && !strb.flush;
  assign accept   = strb.push && (!full || pop);
  assign newEntry = '{data: asmData, pErr: asmPerr, fErr: !strb.bitVal};
  assign headEntry = slots[rdPtr];

  assign rxReady   = (fillCount != '0);
  assign dataOut   = rxReady ? headEntry.data : '0;
  assign parityErr = rxReady && headEntry.pErr;
  assign frameErr  = rxReady && headEntry.fErr;

  // Character assembly
  always_ff @(posedge clk) begin
    if (!rstN || strb.frameStart) begin
      asmData <= '0;
      asmPerr <= 1'b0;
    end else begin
      if (strb.dataBit) asmData[bitIdx] <= strb.bitVal;
      if (strb.parBit)  asmPerr <= (^asmData) ^ strb.bitVal ^ strb.parOdd;
    end
  end

  // Queue storage
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rstN) slots[i] <= '0;
      else if (accept && (wrPtr == PTR_W'(i))) slots[i] <= newEntry;
    end
  end

  // Queue pointers and overrun
  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      fillCount   <= '0;
      overrunFlag <= 1'b0;
    end else begin
      if (accept) wrPtr <= nextPtr(wrPtr);
      if (pop)    rdPtr <= nextPtr(rdPtr);
      if (accept && !pop)      fillCount <= fillCount + CNT_W'(1);
      else if (pop && !accept) fillCount <= fillCount - CNT_W'(1);
      if (strb.push && !accept) overrunFlag <= 1'b1;
      else if (pop)             overrunFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import rxq_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 2,
  parameter int LEN_W       = 2,
  parameter int MIN_BITS    = 5,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(DATA_W),
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              baudTick,
  input  logic              rxLine,
  input  logic              parEnable,
  input  logic              parOdd,
  input  logic [LEN_W-1:0]  lenSel,
  input  logic              readStrobe,
  output logic [DATA_W-1:0] dataOut,
  output logic              rxReady,
  output logic              parityErr,
  output logic              frameErr,
  output logic              overrunFlag
);

  logic             rxSync;
  rxStrobe_t        strb;
  logic [IDX_W-1:0] bitIdx;
  logic [CNT_W-1:0] fillCount;
  logic             framePush;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign rxSync = rxLine;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
      end
      assign rxSync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  assign framePush = strb.push;

  rxq_ctrl #(
    .OSR(OSR), .DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_BITS(MIN_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .baudTick(baudTick),
    .rxIn(rxSync), .parEnCfg(parEnable), .parOddCfg(parOdd),
    .lenCfg(lenSel), .strb(strb), .bitIdx(bitIdx)
  );

  rxq_datapath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIdx(bitIdx),
    .readStrobe(readStrobe), .dataOut(dataOut), .rxReady(rxReady),
    .parityErr(parityErr), .frameErr(frameErr),
    .overrunFlag(overrunFlag), .fillCount(fillCount)
  );

endmodule

// File: rtl/rxq_check.sv
module rxq_check #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              readStrobe,
  input logic [DATA_W-1:0] dataOut,
  input logic              rxReady,
  input logic              parityErr,
  input logic              frameErr,
  input logic              overrunFlag,
  input logic [CNT_W-1:0]  fillCount,
  input logic              framePush
);

  assert_flush_R11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!rxReady && !overrunFlag));

  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == '0 && !framePush) |=> (fillCount == '0));

  assert_head_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && !readStrobe && enable) |=>
      ($stable(dataOut) && $stable(parityErr) && $stable(frameErr)));

  assert_overrun_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> (fillCount == CNT_W'(DEPTH)));

  assert_push_pop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (enable && framePush && readStrobe && fillCount == CNT_W'(DEPTH)) |=>
      (fillCount == CNT_W'(DEPTH) && !overrunFlag));

  assert_tag_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr || frameErr) |-> rxReady);

endmodule

bind serial_rx_fifo rxq_check #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/tb_serial_rx_fifo.sv
`timescale 1ns/1ps
module tb_serial_rx_fifo;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       baudTick = 1'b0;
  logic       rxLine = 1'b1;
  logic       parEnable = 1'b0;
  logic       parOdd = 1'b0;
  logic [1:0] lenSel = 2'd3;
  logic       readStrobe = 1'b0;
  logic [7:0] dataOut;
  logic       rxReady, parityErr, frameErr, overrunFlag;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_rx_fifo dut (
    .clk(clk), .rstN(rstN), .enable(enable), .baudTick(baudTick),
    .rxLine(rxLine), .parEnable(parEnable), .parOdd(parOdd),
    .lenSel(lenSel), .readStrobe(readStrobe), .dataOut(dataOut),
    .rxReady(rxReady), .parityErr(parityErr), .frameErr(frameErr),
    .overrunFlag(overrunFlag)
  );

  // {expFerr, expPerr, expData, stopLow, flipPar, data, parOdd, parEn, len}
  localparam logic [23:0] VECS [9] = '{
    {1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 2'd3},
    {1'b0, 1'b0, 8'h1F, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 2'd0},
    {1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 2'd1},
    {1'b0, 1'b0, 8'h43, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b0, 2'd2},
    {1'b0, 1'b0, 8'h5A, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b1, 2'd3},
    {1'b0, 1'b1, 8'h81, 1'b0, 1'b1, 8'h81, 1'b1, 1'b1, 2'd3},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 2'd3},
    {1'b1, 1'b0, 8'h7E, 1'b1, 1'b0, 8'h7E, 1'b0, 1'b0, 2'd3},
    {1'b0, 1'b0, 8'h15, 1'b0, 1'b0, 8'h15, 1'b1, 1'b1, 2'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One baud tick: line value set 3 clocks ahead of the tick cycle
  task automatic doTick(input logic rxv, input logic rd);
    @(negedge clk); rxLine = rxv;
    repeat (2) @(negedge clk);
    baudTick = 1'b1; readStrobe = rd;
    @(negedge clk);
    baudTick = 1'b0; readStrobe = 1'b0;
  endtask

  task automatic readPulse();
    @(negedge clk); readStrobe = 1'b1;
    @(negedge clk); readStrobe = 1'b0;
  endtask

  task automatic sendFrame(input int len, input logic pe, input logic po,
                           input logic [7:0] d, input logic fp, input logic sl,
                           input int gBit, input logic [15:0] gMask,
                           input logic rdStop, input int cfgAt, input int cutAt);
    logic fb [12];
    int nb;
    logic [7:0] msk;
    lenSel = 2'(len - 5); parEnable = pe; parOdd = po;
    msk = 8'((16'd1 << len) - 1);
    fb[0] = 1'b0;
    for (int i = 0; i < len; i++) fb[1 + i] = d[i];
    nb = 1 + len;
    if (pe) begin fb[nb] = (^(d & msk)) ^ po ^ fp; nb++; end
    fb[nb] = !sl; nb++;
    doTick(1'b1, 1'b0); doTick(1'b1, 1'b0);
    for (int k = 0; k < nb; k++) begin
      if (k == cutAt) begin
        @(negedge clk); enable = 1'b0;
        return;
      end
      if (k == cfgAt) begin parEnable = !parEnable; parOdd = !parOdd; end
      for (int s = 0; s < 16; s++)
        doTick(fb[k] ^ ((k == gBit) && gMask[s]), rdStop && (k == nb - 1) && (s == 9));
    end
    rxLine = 1'b1;
  endtask

  task automatic simple(input logic [7:0] d);
    sendFrame(8, 1'b0, 1'b0, d, 1'b0, 1'b0, -1, 16'h0, 1'b0, -1, -1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 rxReady", rxReady, 0);
    check("R1 flags", {parityErr, frameErr, overrunFlag}, 0);
    check("R1 dataOut", dataOut, 0);
    rstN = 1'b1; enable = 1'b1;
    repeat (4) doTick(1'b1, 1'b0);

    // Vector table: R2 lengths, R5 parity, R6 disabled parity, R7 stop bit
    for (int v = 0; v < 9; v++) begin
      logic [23:0] t;
      t = VECS[v];
      sendFrame(5 + int'(t[1:0]), t[2], t[3], t[11:4], t[12], t[13], -1, 16'h0, 1'b0, -1, -1);
      check("R2 ready", rxReady, 1);
      check("R2 data", dataOut, t[21:14]);
      check("R5 parityErr", parityErr, t[22]);
      check("R7 frameErr", frameErr, t[23]);
      readPulse();
      check("R8 empty after pop", rxReady, 0);
    end

    // R3 majority vote on data bit 2
    sendFrame(8, 1'b0, 1'b0, 8'h04, 1'b0, 1'b0, 3, 16'h0100, 1'b0, -1, -1);
    check("R3 single glitch", dataOut, 8'h04); readPulse();
    sendFrame(8, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 3, 16'h0180, 1'b0, -1, -1);
    check("R3 two-sample flip", dataOut, 8'h04); readPulse();
    sendFrame(8, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 3, 16'h0440, 1'b0, -1, -1);
    check("R3 outside window", dataOut, 8'h00); readPulse();

    // R4 false start: low for six samples only
    doTick(1'b1, 1'b0); doTick(1'b1, 1'b0);
    for (int s = 0; s < 6; s++) doTick(1'b0, 1'b0);
    for (int s = 0; s < 24; s++) doTick(1'b1, 1'b0);
    check("R4 no char", rxReady, 0);
    simple(8'hC6);
    check("R4 recovers", dataOut, 8'hC6); readPulse();

    // R6 config flipped mid-character: even parity, bad parity bit
    sendFrame(8, 1'b1, 1'b0, 8'h0F, 1'b1, 1'b0, -1, 16'h0, 1'b0, 2, -1);
    check("R6 data", dataOut, 8'h0F);
    check("R6 latched parity", parityErr, 1); readPulse();

    // R8 read on empty ignored
    readPulse();
    check("R8 empty read", rxReady, 0);
    simple(8'h77);
    check("R8 after empty read", dataOut, 8'h77); readPulse();

    // R9 overrun
    simple(8'h11); simple(8'h22); simple(8'h33);
    check("R9 overrun set", overrunFlag, 1);
    check("R9 head kept", dataOut, 8'h11);
    readPulse();
    check("R9 second", dataOut, 8'h22);
    check("R9 overrun cleared", overrunFlag, 0);
    readPulse();
    check("R9 third dropped", rxReady, 0);

    // R10 push and pop in the same cycle on a full queue
    simple(8'h44); simple(8'h55);
    sendFrame(8, 1'b0, 1'b0, 8'h66, 1'b0, 1'b0, -1, 16'h0, 1'b1, -1, -1);
    check("R10 no overrun", overrunFlag, 0);
    check("R10 head", dataOut, 8'h55);
    readPulse();
    check("R10 tail", dataOut, 8'h66);
    readPulse();
    check("R10 empty", rxReady, 0);

    // R11 disable mid-character
    simple(8'h12);
    sendFrame(8, 1'b0, 1'b0, 8'hF0, 1'b0, 1'b0, -1, 16'h0, 1'b0, -1, 4);
    @(negedge clk);
    check("R11 flushed", rxReady, 0);
    rxLine = 1'b1;
    simple(8'h34);
    check("R11 ignored while off", rxReady, 0);
    enable = 1'b1;
    simple(8'h56);
    check("R11 clean restart", dataOut, 8'h56);
    check("R11 flags clean", {parityErr, frameErr, overrunFlag}, 0);
    readPulse();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule